// File: doc/BRIEF.md
# Slow-Tick System Timer

This block is a bus-mapped system timer. It advances on a slow reference tick, nominally 32768 Hz, which arrives as a one-cycle enable pulse in the bus clock domain. It holds three timing functions. The first is a free-running real-time counter behind a programmable prescaler. The second is an alarm that compares against the absolute value of that counter. The third is a periodic interval timer that counts raw slow ticks.

Every timing event sets a flag in a shared status word, and any read of that word clears it. A set-only enable register and a clear-only disable register act on one interrupt mask. The single interrupt output is high while a pending flag is also enabled.

Software uses the counter as a monotonic time source. It uses the interval timer for a fixed-rate tick. For one-shot events it writes an absolute counter value into the alarm.

Top module: `stimer_top`

## Requirements
- R1: After reset these registers read as follows: mode 0x8000, period 0, alarm 0, counter 0, status 0 and mask 0. The interrupt output is low.
- R2: The counter advances once every P slow ticks, where P is the mode register at 0x00. Writing the mode register restarts the prescale count. P=1 advances the counter on every tick, and P=0 means 65536 ticks.
- R3: The counter (0x0C) is CNT_W bits wide, 20 by default, and wraps from all-ones to zero.
- R4: The alarm flag (status bit 3) sets when the counter advances to a value equal to the alarm register (0x08). If the alarm is loaded with the current count, the flag sets only after a full counter wrap.
- R5: With period N written at 0x04, the interval flag (status bit 0) sets on every Nth slow tick. Writing 0x04 restarts the interval count from zero. N=0 means 65536 ticks.
- R6: Every counter advance sets the increment flag (status bit 2).
- R7: A read of the status register at 0x10 clears all of its flags. A flag that sets in the same cycle as the read stays set.
- R8: Writing ones to 0x14 sets mask bits and writing ones to 0x18 clears them. The mask reads back at 0x1C. The interrupt output is high exactly while status AND mask is non-zero.
- R9: The watchdog flag (status bit 1) never sets, even when its mask bit is set. The counter at 0x0C is read-only, so a write to it has no effect.
- R10: Two reads of the counter return the same value when no counter advance happened between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle slow-tick enable pulse |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Shared interrupt request |

## Verification
Read data is combinational, so a register value is due in the same cycle as the read strobe. A write, a tick, or the clear caused by a status read becomes visible one clock edge later. The interrupt output follows status and mask with no added delay, so it settles in the cycle after the edge that updates either of them.

The driver changes inputs on the falling clock edge. The monitor samples a quarter period later, inside the low phase, which is after inputs settle and before the next rising edge commits them. Each expected value is queued by the driver at the moment it issues the access, and the monitor compares it against the first access it observes.

// File: rtl/stimer_pkg.sv
package stimer_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_MODE   = 5'h00;
    localparam logic [ADDR_W-1:0] A_PERIOD = 5'h04;
    localparam logic [ADDR_W-1:0] A_ALARM  = 5'h08;
    localparam logic [ADDR_W-1:0] A_COUNT  = 5'h0C;
    localparam logic [ADDR_W-1:0] A_STAT   = 5'h10;
    localparam logic [ADDR_W-1:0] A_IEN    = 5'h14;
    localparam logic [ADDR_W-1:0] A_IDIS   = 5'h18;
    localparam logic [ADDR_W-1:0] A_MASK   = 5'h1C;

    localparam int NFLAG    = 4;
    localparam int F_PIT    = 0;
    localparam int F_WDOG   = 1;
    localparam int F_INC    = 2;
    localparam int F_ALARM  = 3;

    typedef logic [NFLAG-1:0] flag_t;
endpackage

// File: rtl/stimer_count.sv
module stimer_count #(
    parameter int CNT_W = 20,
    parameter int PRE_W = 16,
    parameter logic [PRE_W-1:0] PRE_RST = 16'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             pre_wr_i,
    input  logic [PRE_W-1:0] pre_val_i,
    input  logic             alm_wr_i,
    input  logic [CNT_W-1:0] alm_val_i,
    output logic [PRE_W-1:0] pre_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] alm_o,
    output logic             inc_o,
    output logic             hit_o
);
    typedef struct packed {
        logic [PRE_W-1:0] psc;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] alm;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [PRE_W-1:0] pre_last;
    logic [CNT_W-1:0] cnt_next;

    always_comb begin
        st_d     = st_q;
        pre_last = st_q.pre - PRE_W'(1);
        cnt_next = st_q.cnt + CNT_W'(1);
        inc_o    = tick_i && (st_q.psc == pre_last);
        hit_o    = inc_o && (cnt_next == st_q.alm);
        if (tick_i) begin
            st_d.psc = inc_o ? '0 : st_q.psc + PRE_W'(1);
        end
        if (inc_o) begin
            st_d.cnt = cnt_next;
        end
        if (pre_wr_i) begin
            st_d.pre = pre_val_i;
            st_d.psc = '0;
        end
        if (alm_wr_i) begin
            st_d.alm = alm_val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.psc <= '0;
            st_q.pre <= PRE_RST;
            st_q.cnt <= '0;
            st_q.alm <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pre_o = st_q.pre;
    assign cnt_o = st_q.cnt;
    assign alm_o = st_q.alm;

    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_o && (st_q.cnt == '1)) |=> (st_q.cnt == '0));

    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_o |=> $stable(st_q.cnt));

    // R4
    alarm_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && !alm_wr_i) |=> (st_q.cnt == st_q.alm));
endmodule

// File: rtl/stimer_pit.sv
module stimer_pit #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             per_wr_i,
    input  logic [PER_W-1:0] per_val_i,
    output logic [PER_W-1:0] per_o,
    output logic             evt_o
);
    typedef struct packed {
        logic [PER_W-1:0] per;
        logic [PER_W-1:0] cnt;
    } pit_st_t;

    pit_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        evt_o = tick_i && (st_q.cnt == (st_q.per - PER_W'(1)));
        if (tick_i) begin
            st_d.cnt = evt_o ? '0 : st_q.cnt + PER_W'(1);
        end
        if (per_wr_i) begin
            st_d.per = per_val_i;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign per_o = st_q.per;

    // R5
    pit_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr_i |=> (st_q.cnt == '0));
endmodule

// File: rtl/stimer_irqc.sv
module stimer_irqc
    import stimer_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  flag_t evt_i,
    input  logic  rd_clr_i,
    input  logic  en_wr_i,
    input  logic  dis_wr_i,
    input  flag_t wbits_i,
    output flag_t stat_o,
    output flag_t mask_o,
    output logic  irq_o
);
    typedef struct packed {
        flag_t stat;
        flag_t mask;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = (rd_clr_i ? '0 : st_q.stat) | evt_i;
        if (en_wr_i) begin
            st_d.mask = st_q.mask | wbits_i;
        end
        if (dis_wr_i) begin
            st_d.mask = st_q.mask & ~wbits_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.stat & st_q.mask);

    // R7
    rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && (evt_i == '0)) |=> (st_q.stat == '0));

    // R7
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((st_q.stat & $past(evt_i)) == $past(evt_i)));

    // R8
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr_i |=> ((st_q.mask & $past(wbits_i)) == $past(wbits_i)));

    // R8
    dis_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_wr_i |=> ((st_q.mask & $past(wbits_i)) == '0));

    // R9
    wdog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.stat[F_WDOG]);
endmodule

// File: rtl/stimer_top.sv
module stimer_top
    import stimer_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int PRE_W = 16,
    parameter int PER_W = 16,
    parameter logic [PRE_W-1:0] PRE_RST = 16'h8000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        bus_sel_i,
    input  logic        bus_we_i,
    input  logic [4:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        irq_o
);
    logic wr, rd;
    logic [PRE_W-1:0] pre;
    logic [PER_W-1:0] per;
    logic [CNT_W-1:0] cnt, alm;
    logic inc, hit, pit_evt;
    flag_t evt, stat, mask;
    logic unused_wdata;

    assign wr = bus_sel_i && bus_we_i;
    assign rd = bus_sel_i && !bus_we_i;
    assign unused_wdata = ^bus_wdata_i;

    stimer_count #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .pre_wr_i  (wr && (bus_addr_i == A_MODE)),
        .pre_val_i (bus_wdata_i[PRE_W-1:0]),
        .alm_wr_i  (wr && (bus_addr_i == A_ALARM)),
        .alm_val_i (bus_wdata_i[CNT_W-1:0]),
        .pre_o     (pre),
        .cnt_o     (cnt),
        .alm_o     (alm),
        .inc_o     (inc),
        .hit_o     (hit)
    );

    stimer_pit #(.PER_W(PER_W)) u_pit (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .per_wr_i  (wr && (bus_addr_i == A_PERIOD)),
        .per_val_i (bus_wdata_i[PER_W-1:0]),
        .per_o     (per),
        .evt_o     (pit_evt)
    );

    always_comb begin
        evt          = '0;
        evt[F_PIT]   = pit_evt;
        evt[F_WDOG]  = 1'b0;
        evt[F_INC]   = inc;
        evt[F_ALARM] = hit;
    end

    stimer_irqc u_irqc (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt),
        .rd_clr_i (rd && (bus_addr_i == A_STAT)),
        .en_wr_i  (wr && (bus_addr_i == A_IEN)),
        .dis_wr_i (wr && (bus_addr_i == A_IDIS)),
        .wbits_i  (bus_wdata_i[NFLAG-1:0]),
        .stat_o   (stat),
        .mask_o   (mask),
        .irq_o    (irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_MODE:   bus_rdata_o = 32'(pre);
            A_PERIOD: bus_rdata_o = 32'(per);
            A_ALARM:  bus_rdata_o = 32'(alm);
            A_COUNT:  bus_rdata_o = 32'(cnt);
            A_STAT:   bus_rdata_o = 32'(stat);
            A_MASK:   bus_rdata_o = 32'(mask);
            default:  bus_rdata_o = '0;
        endcase
    end
endmodule

// File: tb/stimer_top_tb_top.sv
module stimer_top_tb_top;
    localparam int TB_CNT_W = 8;
    localparam int CMAX     = 1 << TB_CNT_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        probe = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int exp_cnt = 0;
    int tb_pre = 32768;
    int tb_psc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
        bit          is_irq;
        bit          chk;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    stimer_top #(.CNT_W(TB_CNT_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .bus_sel_i   (sel),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    // Monitor: samples a quarter period after the falling edge.
    always @(negedge clk) begin
        #5;
        if ((sel && !we) || probe) begin
            logic [31:0] act;
            item_t it;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL monitor: unexpected access, act=%h exp=none", rdata);
            end else begin
                it = exp_q.pop_front();
                act = it.is_irq ? {31'b0, irq} : rdata;
                if (it.chk) begin
                    n_chk++;
                    if (act !== it.exp) begin
                        n_fail++;
                        $display("FAIL %s: act=%h exp=%h", it.tag, act, it.exp);
                    end
                end
            end
        end
    end

    task automatic push(input logic [31:0] e, input string t, input bit ir, input bit c);
        item_t it;
        it.exp = e; it.tag = t; it.is_irq = ir; it.chk = c;
        exp_q.push_back(it);
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, input logic [31:0] e, input string t, input bit c);
        @(negedge clk);
        push(e, t, 1'b0, c);
        sel = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic irq_chk(input logic e, input string t);
        @(negedge clk);
        push({31'b0, e}, t, 1'b1, 1'b1);
        probe = 1'b1;
        @(negedge clk);
        probe = 1'b0;
    endtask

    task automatic model_tick();
        tb_psc++;
        if (tb_psc == tb_pre) begin
            tb_psc = 0;
            exp_cnt = (exp_cnt + 1) % CMAX;
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            model_tick();
        end
    endtask

    task automatic tick_read_stat(input logic [31:0] e, input string t);
        @(negedge clk);
        push(e, t, 1'b0, 1'b1);
        tick = 1'b1; sel = 1'b1; we = 1'b0; addr = 5'h10;
        @(negedge clk);
        tick = 1'b0; sel = 1'b0;
        model_tick();
    endtask

    task automatic set_pre(input int p);
        bus_wr(5'h00, p);
        tb_pre = p; tb_psc = 0;
    endtask

    task automatic clr_stat();
        bus_rd(5'h10, '0, "clr", 1'b0);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(5'h00, 32'h8000, "R1 mode", 1'b1);
        bus_rd(5'h04, 32'h0, "R1 period", 1'b1);
        bus_rd(5'h08, 32'h0, "R1 alarm", 1'b1);
        bus_rd(5'h0C, 32'h0, "R1 count", 1'b1);
        bus_rd(5'h10, 32'h0, "R1 status", 1'b1);
        bus_rd(5'h1C, 32'h0, "R1 mask", 1'b1);
        irq_chk(1'b0, "R1 irq");

        // R2 prescale 1, R6 increment flag
        set_pre(1);
        ticks(3);
        bus_rd(5'h0C, 32'd3, "R2 count pre1", 1'b1);
        bus_rd(5'h10, 32'h4, "R6 inc flag", 1'b1);
        bus_rd(5'h10, 32'h0, "R7 cleared", 1'b1);

        // R2 prescale 3
        set_pre(3);
        ticks(6);
        bus_rd(5'h0C, 32'd5, "R2 count pre3", 1'b1);
        // R10 stability
        bus_rd(5'h0C, 32'd5, "R10 reread", 1'b1);

        // R9 counter is read-only
        bus_wr(5'h0C, 32'h33);
        bus_rd(5'h0C, 32'd5, "R9 count ro", 1'b1);

        // R5 interval timer
        set_pre(1);
        bus_wr(5'h04, 32'd4);
        clr_stat();
        ticks(3);
        bus_rd(5'h10, 32'h4, "R5 before N", 1'b1);
        ticks(1);
        bus_rd(5'h10, 32'h5, "R5 at N", 1'b1);
        ticks(2);
        bus_wr(5'h04, 32'd4);
        clr_stat();
        ticks(3);
        bus_rd(5'h10, 32'h4, "R5 restart", 1'b1);
        ticks(1);
        bus_rd(5'h10, 32'h5, "R5 restart N", 1'b1);
        bus_wr(5'h04, 32'd0);

        // R7 same-cycle event wins over clear
        clr_stat();
        tick_read_stat(32'h0, "R7 read with tick");
        bus_rd(5'h10, 32'h4, "R7 event kept", 1'b1);

        // R4 alarm ahead
        bus_wr(5'h08, (exp_cnt + 2) % CMAX);
        clr_stat();
        ticks(1);
        bus_rd(5'h10, 32'h4, "R4 not yet", 1'b1);
        ticks(1);
        bus_rd(5'h10, 32'hC, "R4 alarm", 1'b1);

        // R4 alarm at current count waits a full wrap
        bus_wr(5'h08, exp_cnt);
        clr_stat();
        ticks(CMAX - 1);
        bus_rd(5'h10, 32'h4, "R4 no early match", 1'b1);
        ticks(1);
        bus_rd(5'h10, 32'hC, "R4 after wrap", 1'b1);

        // R3 wrap
        while (exp_cnt != CMAX - 1) ticks(1);
        bus_rd(5'h0C, CMAX - 1, "R3 top", 1'b1);
        ticks(1);
        bus_rd(5'h0C, 32'h0, "R3 wrapped", 1'b1);

        // R8 mask and interrupt
        clr_stat();
        ticks(1);
        bus_wr(5'h14, 32'h8);
        bus_rd(5'h1C, 32'h8, "R8 mask en", 1'b1);
        irq_chk(1'b0, "R8 irq unmatched");
        bus_wr(5'h14, 32'h4);
        bus_rd(5'h1C, 32'hC, "R8 mask en2", 1'b1);
        irq_chk(1'b1, "R8 irq high");
        bus_wr(5'h18, 32'h4);
        bus_rd(5'h1C, 32'h8, "R8 mask dis", 1'b1);
        irq_chk(1'b0, "R8 irq low");

        // R9 watchdog bit maskable but never set
        bus_wr(5'h14, 32'h2);
        bus_rd(5'h1C, 32'hA, "R9 wdog mask", 1'b1);
        irq_chk(1'b0, "R9 irq");
        bus_rd(5'h10, 32'h4, "R9 wdog flag", 1'b1);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule